// File: doc/BRIEF.md
# Machine-Mode CSR File

This block is the control and status register store for a small 32-bit hart that runs in machine mode, with an optional user mode. The pipeline reaches it through a single access port. A request carries a 12-bit register address, a write enable, write data and the current privilege level. The read data and an error flag come back in the same cycle, and a write takes effect at the next rising clock edge. An access that fails the privilege check, or that names a register this block does not implement, raises the error flag and leaves every register unchanged.

The block also watches the trap machinery. A trap-entry strobe supplies the cause code, an interrupt flag, the pc, the instruction word and a fault value. From these the block fills the exception pc, cause and trap-value registers and saves the global interrupt enable. A return strobe restores the enable. Each register applies its own write rules:

- the timer-pending bit cannot be written by software;
- the trap-vector read hides bit 1;
- the cause register keeps only its top bit and a 4-bit code;
- the identification registers ignore writes;
- the unused performance counters read as zero.

A parameter adds a group of four debug registers.

Top module: `mcsr_file`

## Requirements
- R1: An access whose address bits [9:8] exceed `priv_i` (0 = user, 3 = machine) returns `csr_err_o`=1, and a write in that case changes no register.
- R2: An access to an address that is not implemented returns `csr_err_o`=1. When `DEBUG_EN`=0 this includes 0x7B0 to 0x7B3.
- R3: A write to the debug control register (0x7B0) keeps only the bits in 32'h0000_89C4, and every other bit reads as 0.
- R4: With `DEBUG_EN`=1, 0x7B1, 0x7B2 and 0x7B3 are plain 32-bit read/write registers.
- R5: A write to the pending register (0x344) updates only the bits of `IRQ_MASK` other than bit 7. Bit 7 always reads as `mtip_i` and cannot be written.
- R6: A write to the enable register (0x304) updates only the bits of `IRQ_MASK`.
- R7: A read of the trap-vector register (0x305) returns the stored value with bit 1 cleared.
- R8: A write to the cause register (0x342) stores only bit 31 and bits [3:0].
- R9: The identification registers hold fixed values, and writes to them are ignored without error:
  - 0x301 reads 32'h4000_1104 (0x4000_1100 without compressed support);
  - 0xF11 reads 0x669;
  - 0xF12 reads `ARCH_ID`;
  - 0xF13 reads 1;
  - 0xF14 reads `HART_ID`.
- R10: The counters and event selectors 3 to 31 read as zero without error. These sit at 0xB03–0xB1F, 0xB83–0xB9F, 0x323–0x33F, 0xC03–0xC1F and 0xC83–0xC9F.
- R11: On `mret_i`, the status MIE bit (bit 3 of 0x300) takes the value of MPIE (bit 7), and MPIE becomes 1. The status register reads with bits 12:11 fixed at 2'b11.
- R12: On `trap_i`, the following updates happen:
  - MPIE takes MIE, and MIE is cleared;
  - the exception pc (0x341) gets `trap_pc_i` with the alignment mask applied;
  - the cause register (0x342) gets {`trap_irq_i`, 27'b0, code};
  - an exception code of 11 (environment call) is reported as 8 plus the machine level, which is 11.
- R13: On a trap, the trap-value register (0x343) is loaded according to the trap type:

  | Trap | Trap-value register |
  |---|---|
  | Exception code 2, instruction bits [1:0] = 2'b11 | the whole instruction |
  | Exception code 2, other instructions | the instruction's low 16 bits |
  | Exception code 3 | `trap_pc_i` |
  | Any other exception | `trap_tval_i` |
  | Interrupt | 0 |
- R14: The alignment mask clears bit 0 when `COMPRESSED`=1, and bits [1:0] otherwise. Software writes to the exception pc use the same mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | Access request |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| priv_i | input | 2 | Current privilege level |
| csr_rdata_o | output | 32 | Read data, same cycle |
| csr_err_o | output | 1 | Access rejected |
| mtip_i | input | 1 | Timer interrupt pending from the timer |
| trap_i | input | 1 | Trap entry strobe |
| trap_irq_i | input | 1 | The trap is an interrupt |
| trap_cause_i | input | 4 | Trap cause code |
| trap_pc_i | input | 32 | pc of the trapping instruction |
| trap_instr_i | input | 32 | Trapping instruction word |
| trap_tval_i | input | 32 | Fault value for other exceptions |
| mret_i | input | 1 | Trap return strobe |
| irq_en_o | output | 1 | Global machine interrupt enable |
| mtvec_o | output | 32 | Trap vector, bit 1 cleared |
| mepc_o | output | 32 | Exception pc |

## Verification
The read port is combinational, so a bad write mask or a wrong stored field shows on `csr_rdata_o` in the first read after the clock edge that applied the write. Errors in trap-entry or return bookkeeping appear on `irq_en_o` one cycle after the strobe. They also appear in the next read of the status, cause, exception pc and trap-value registers. A wrong decode or privilege comparison shows at once on `csr_err_o` during the request cycle. A write that leaked past a rejection shows on the next permitted read of the same register.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_MSTATUS, SEL_MISA, SEL_MIE, SEL_MTVEC, SEL_MSCRATCH,
    SEL_MEPC, SEL_MCAUSE, SEL_MTVAL, SEL_MIP, SEL_ID, SEL_ZERO, SEL_DBG
  } csr_sel_e;

  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;
  localparam logic [11:0] A_DCSR     = 12'h7B0;
  localparam logic [11:0] A_DPC      = 12'h7B1;
  localparam logic [11:0] A_DSCR0    = 12'h7B2;
  localparam logic [11:0] A_DSCR1    = 12'h7B3;
  localparam logic [11:0] A_VENDOR   = 12'hF11;
  localparam logic [11:0] A_ARCH     = 12'hF12;
  localparam logic [11:0] A_IMPL     = 12'hF13;
  localparam logic [11:0] A_HART     = 12'hF14;

  localparam int unsigned ST_MIE_BIT  = 3;
  localparam int unsigned ST_MPIE_BIT = 7;
  localparam int unsigned MTIP_BIT    = 7;
  localparam logic [31:0] DCSR_KEEP   = 32'h0000_89C4;
  localparam logic [31:0] CAUSE_KEEP  = 32'h8000_000F;
  localparam logic [31:0] VENDOR_VAL  = 32'h0000_0669;
  localparam logic [31:0] IMPL_VAL    = 32'h0000_0001;
  localparam logic [3:0]  ECALL_CODE  = 4'd11;
  localparam logic [1:0]  PRIV_MACH   = 2'd3;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter bit DEBUG_EN = 1'b1
) (
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  output csr_sel_e    sel_o,
  output logic        err_o
);
  logic [6:0] blk;
  logic       zero_hit;

  assign blk      = addr_i[11:5];
  // counter/event blocks 3..31
  assign zero_hit = (addr_i[4:0] >= 5'd3) &&
                    (blk == 7'h58 || blk == 7'h5C || blk == 7'h19 ||
                     blk == 7'h60 || blk == 7'h64);

  always_comb begin
    sel_o = SEL_NONE;
    if (zero_hit) sel_o = SEL_ZERO;
    else begin
      case (addr_i)
        A_MSTATUS:  sel_o = SEL_MSTATUS;
        A_MISA:     sel_o = SEL_MISA;
        A_MIE:      sel_o = SEL_MIE;
        A_MTVEC:    sel_o = SEL_MTVEC;
        A_MSCRATCH: sel_o = SEL_MSCRATCH;
        A_MEPC:     sel_o = SEL_MEPC;
        A_MCAUSE:   sel_o = SEL_MCAUSE;
        A_MTVAL:    sel_o = SEL_MTVAL;
        A_MIP:      sel_o = SEL_MIP;
        A_VENDOR, A_ARCH, A_IMPL, A_HART: sel_o = SEL_ID;
        A_DCSR, A_DPC, A_DSCR0, A_DSCR1:  sel_o = DEBUG_EN ? SEL_DBG : SEL_NONE;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end

  assign err_o = (sel_o == SEL_NONE) || (priv_i < addr_i[9:8]);
endmodule

// File: rtl/mcsr_trap_calc.sv
module mcsr_trap_calc
  import mcsr_pkg::*;
#(
  parameter logic [31:0] PC_MASK = 32'hFFFF_FFFE
) (
  input  logic        irq_i,
  input  logic [3:0]  code_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] tval_i,
  output logic [31:0] cause_o,
  output logic [31:0] epc_o,
  output logic [31:0] tval_o
);
  logic [3:0] code_adj;

  assign code_adj = (!irq_i && code_i == ECALL_CODE) ? 4'(8 + PRIV_MACH) : code_i;
  assign cause_o  = {irq_i, 27'b0, code_adj};
  assign epc_o    = pc_i & PC_MASK;

  always_comb begin
    if (irq_i)              tval_o = '0;
    else if (code_i == 4'd2) tval_o = (instr_i[1:0] == 2'b11) ? instr_i : {16'b0, instr_i[15:0]};
    else if (code_i == 4'd3) tval_o = pc_i;
    else                     tval_o = tval_i;
  end
endmodule

// File: rtl/mcsr_dbg_regs.sv
module mcsr_dbg_regs
  import mcsr_pkg::*;
#(
  parameter bit DEBUG_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  idx_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  if (DEBUG_EN) begin : g_dbg
    logic [31:0] regs_q [4];
    for (genvar i = 0; i < 4; i++) begin : g_reg
      localparam logic [31:0] KEEP = (i == 0) ? DCSR_KEEP : 32'hFFFF_FFFF;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        regs_q[i] <= '0;
        else if (wr_i && idx_i == 2'(i))    regs_q[i] <= wdata_i & KEEP;
      end
    end
    assign rdata_o = regs_q[idx_i];
  end else begin : g_nodbg
    logic unused_dbg;
    assign unused_dbg = ^{clk_i, rst_ni, wr_i, idx_i, wdata_i};
    assign rdata_o    = '0;
  end
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter bit          DEBUG_EN   = 1'b1,
  parameter bit          COMPRESSED = 1'b1,
  parameter logic [31:0] IRQ_MASK   = 32'h0000_0888,
  parameter logic [31:0] ARCH_ID    = 32'h0,
  parameter logic [31:0] HART_ID    = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_req_i,
  input  logic        csr_we_i,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  input  logic [1:0]  priv_i,
  output logic [31:0] csr_rdata_o,
  output logic        csr_err_o,
  input  logic        mtip_i,
  input  logic        trap_i,
  input  logic        trap_irq_i,
  input  logic [3:0]  trap_cause_i,
  input  logic [31:0] trap_pc_i,
  input  logic [31:0] trap_instr_i,
  input  logic [31:0] trap_tval_i,
  input  logic        mret_i,
  output logic        irq_en_o,
  output logic [31:0] mtvec_o,
  output logic [31:0] mepc_o
);
  localparam logic [31:0] PC_MASK  = COMPRESSED ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
  localparam logic [31:0] MISA_VAL = 32'h4000_1100 | (COMPRESSED ? 32'h4 : 32'h0);
  localparam logic [31:0] MIP_WR   = IRQ_MASK & ~(32'h1 << MTIP_BIT);

  csr_sel_e    sel;
  logic        dec_err, wr_ok;
  logic        mie_q, mpie_q;
  logic [31:0] mie_r_q, mip_q, mtvec_q, mscratch_q, mepc_q, mcause_q, mtval_q;
  logic [31:0] t_cause, t_epc, t_tval, dbg_rdata, id_val, mstatus_rd, mip_rd;

  mcsr_decode #(.DEBUG_EN(DEBUG_EN)) u_dec (
    .addr_i(csr_addr_i), .priv_i(priv_i), .sel_o(sel), .err_o(dec_err)
  );

  mcsr_trap_calc #(.PC_MASK(PC_MASK)) u_trap (
    .irq_i(trap_irq_i), .code_i(trap_cause_i), .pc_i(trap_pc_i),
    .instr_i(trap_instr_i), .tval_i(trap_tval_i),
    .cause_o(t_cause), .epc_o(t_epc), .tval_o(t_tval)
  );

  mcsr_dbg_regs #(.DEBUG_EN(DEBUG_EN)) u_dbg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_ok && sel == SEL_DBG),
    .idx_i(csr_addr_i[1:0]), .wdata_i(csr_wdata_i), .rdata_o(dbg_rdata)
  );

  assign csr_err_o = csr_req_i && dec_err;
  assign wr_ok     = csr_req_i && csr_we_i && !dec_err;

  // trap and return take precedence over software writes of the same register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      mepc_q   <= '0;
      mcause_q <= '0;
      mtval_q  <= '0;
    end else if (trap_i) begin
      mie_q    <= 1'b0;
      mpie_q   <= mie_q;
      mepc_q   <= t_epc;
      mcause_q <= t_cause;
      mtval_q  <= t_tval;
    end else if (mret_i) begin
      mie_q    <= mpie_q;
      mpie_q   <= 1'b1;
    end else if (wr_ok) begin
      case (sel)
        SEL_MSTATUS: begin
          mie_q  <= csr_wdata_i[ST_MIE_BIT];
          mpie_q <= csr_wdata_i[ST_MPIE_BIT];
        end
        SEL_MEPC:   mepc_q   <= csr_wdata_i & PC_MASK;
        SEL_MCAUSE: mcause_q <= csr_wdata_i & CAUSE_KEEP;
        SEL_MTVAL:  mtval_q  <= csr_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_r_q    <= '0;
      mip_q      <= '0;
      mtvec_q    <= '0;
      mscratch_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_MIE:      mie_r_q    <= csr_wdata_i & IRQ_MASK;
        SEL_MIP:      mip_q      <= csr_wdata_i & MIP_WR;
        SEL_MTVEC:    mtvec_q    <= csr_wdata_i;
        SEL_MSCRATCH: mscratch_q <= csr_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (csr_addr_i[2:0])
      3'd1:    id_val = VENDOR_VAL;
      3'd2:    id_val = ARCH_ID;
      3'd3:    id_val = IMPL_VAL;
      default: id_val = HART_ID;
    endcase
  end

  assign mstatus_rd = {19'b0, 2'b11, 3'b0, mpie_q, 3'b0, mie_q, 3'b0};
  assign mip_rd     = mip_q | ({31'b0, mtip_i & IRQ_MASK[MTIP_BIT]} << MTIP_BIT);

  always_comb begin
    csr_rdata_o = '0;
    if (csr_req_i && !dec_err) begin
      case (sel)
        SEL_MSTATUS:  csr_rdata_o = mstatus_rd;
        SEL_MISA:     csr_rdata_o = MISA_VAL;
        SEL_MIE:      csr_rdata_o = mie_r_q;
        SEL_MTVEC:    csr_rdata_o = mtvec_q & ~32'h2;
        SEL_MSCRATCH: csr_rdata_o = mscratch_q;
        SEL_MEPC:     csr_rdata_o = mepc_q;
        SEL_MCAUSE:   csr_rdata_o = mcause_q;
        SEL_MTVAL:    csr_rdata_o = mtval_q;
        SEL_MIP:      csr_rdata_o = mip_rd;
        SEL_ID:       csr_rdata_o = id_val;
        SEL_DBG:      csr_rdata_o = dbg_rdata;
        default:      csr_rdata_o = '0;
      endcase
    end
  end

  assign irq_en_o = mie_q;
  assign mtvec_o  = mtvec_q & ~32'h2;
  assign mepc_o   = mepc_q;
endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk
  import mcsr_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        csr_req_i,
  input logic        csr_we_i,
  input logic [11:0] csr_addr_i,
  input logic [1:0]  priv_i,
  input logic [31:0] csr_rdata_o,
  input logic        csr_err_o,
  input logic        mtip_i,
  input logic        trap_i,
  input logic        mret_i,
  input logic        irq_en_o,
  input logic [31:0] mepc_o
);
  logic rd_ok;
  assign rd_ok = csr_req_i && !csr_err_o;

  AST_PRIV_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && (priv_i < csr_addr_i[9:8]) |-> csr_err_o) else $error("AST_PRIV_ERR"); // R1
  AST_PRIV_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_we_i && csr_err_o && !trap_i |=> $stable(mepc_o)) else $error("AST_PRIV_NO_WRITE"); // R1
  AST_DCSR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && csr_addr_i == A_DCSR |-> (csr_rdata_o & ~DCSR_KEEP) == 32'h0) else $error("AST_DCSR_MASK"); // R3
  AST_MTIP_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && csr_addr_i == A_MIP |-> csr_rdata_o[MTIP_BIT] == mtip_i) else $error("AST_MTIP_RO"); // R5
  AST_MTVEC_BIT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && csr_addr_i == A_MTVEC |-> !csr_rdata_o[1]) else $error("AST_MTVEC_BIT1"); // R7
  AST_MCAUSE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && csr_addr_i == A_MCAUSE |-> csr_rdata_o[30:4] == 27'h0) else $error("AST_MCAUSE_MASK"); // R8
  AST_TRAP_MIE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !irq_en_o) else $error("AST_TRAP_MIE_CLR"); // R12
  AST_MRET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i && !trap_i && rd_ok && csr_addr_i == A_MSTATUS |=>
      irq_en_o == $past(csr_rdata_o[ST_MPIE_BIT])) else $error("AST_MRET_RESTORE"); // R11
endmodule

bind mcsr_file mcsr_file_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .csr_req_i(csr_req_i), .csr_we_i(csr_we_i),
  .csr_addr_i(csr_addr_i), .priv_i(priv_i), .csr_rdata_o(csr_rdata_o),
  .csr_err_o(csr_err_o), .mtip_i(mtip_i), .trap_i(trap_i), .mret_i(mret_i),
  .irq_en_o(irq_en_o), .mepc_o(mepc_o)
);

// File: tb/mcsr_file_tb_top.sv
`timescale 1ns/1ps
module mcsr_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_req = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [1:0]  priv = 2'd3;
  logic [31:0] rdata, rdata_nd, mtvec, mepc, mtvec_nd, mepc_nd;
  logic        err, err_nd, irq_en, irq_en_nd;
  logic        mtip = 1'b0, trap = 1'b0, trap_irq = 1'b0, mret = 1'b0;
  logic [3:0]  trap_cause = '0;
  logic [31:0] trap_pc = '0, trap_instr = '0, trap_tval = '0;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  mcsr_file dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .csr_req_i(csr_req), .csr_we_i(csr_we),
    .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .priv_i(priv),
    .csr_rdata_o(rdata), .csr_err_o(err), .mtip_i(mtip), .trap_i(trap),
    .trap_irq_i(trap_irq), .trap_cause_i(trap_cause), .trap_pc_i(trap_pc),
    .trap_instr_i(trap_instr), .trap_tval_i(trap_tval), .mret_i(mret),
    .irq_en_o(irq_en), .mtvec_o(mtvec), .mepc_o(mepc)
  );

  mcsr_file #(.DEBUG_EN(1'b0)) dut_nodbg_i (
    .clk_i(clk), .rst_ni(rst_ni), .csr_req_i(csr_req), .csr_we_i(csr_we),
    .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .priv_i(priv),
    .csr_rdata_o(rdata_nd), .csr_err_o(err_nd), .mtip_i(mtip), .trap_i(trap),
    .trap_irq_i(trap_irq), .trap_cause_i(trap_cause), .trap_pc_i(trap_pc),
    .trap_instr_i(trap_instr), .trap_tval_i(trap_tval), .mret_i(mret),
    .irq_en_o(irq_en_nd), .mtvec_o(mtvec_nd), .mepc_o(mepc_nd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] p,
                    output logic [31:0] d, output logic e);
    @(negedge clk);
    csr_req = 1'b1; csr_we = 1'b0; csr_addr = a; priv = p;
    #1;
    d = rdata; e = err;
    csr_req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v, input logic [1:0] p);
    @(negedge clk);
    csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = v; priv = p;
    @(posedge clk); #1;
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, 2'd3, d, e);
    check(req, {31'b0, e}, 32'd0);
    check(req, d, exp);
  endtask

  task automatic do_trap(input logic irq, input logic [3:0] c, input logic [31:0] pc,
                         input logic [31:0] ins, input logic [31:0] tv);
    @(negedge clk);
    trap = 1'b1; trap_irq = irq; trap_cause = c; trap_pc = pc; trap_instr = ins; trap_tval = tv;
    @(posedge clk); #1;
    trap = 1'b0;
  endtask

  task automatic do_mret();
    @(negedge clk); mret = 1'b1;
    @(posedge clk); #1; mret = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R11 reset status", 12'h300, 32'h0000_1800);
    check("R12 reset irq_en", {31'b0, irq_en}, 32'd0);
    rd_chk("R9 vendor", 12'hF11, 32'h669);
    rd_chk("R9 impl", 12'hF13, 32'h1);
    rd_chk("R9 arch", 12'hF12, 32'h0);
    rd_chk("R9 hart", 12'hF14, 32'h0);
    rd_chk("R9 isa", 12'h301, 32'h4000_1104);
  endtask

  task automatic t_id_ignore();
    wr(12'h301, 32'h0, 2'd3);
    wr(12'hF11, 32'hFFFF_FFFF, 2'd3);
    rd_chk("R9 isa after write", 12'h301, 32'h4000_1104);
    rd_chk("R9 vendor after write", 12'hF11, 32'h669);
  endtask

  task automatic t_privilege();
    logic [31:0] d; logic e;
    wr(12'h340, 32'hCAFE_0001, 2'd3);
    wr(12'h340, 32'h1111_1111, 2'd0);
    rd_chk("R1 scratch unchanged", 12'h340, 32'hCAFE_0001);
    rd(12'h300, 2'd0, d, e);
    check("R1 user read of status", {31'b0, e}, 32'd1);
    rd(12'hC83, 2'd0, d, e);
    check("R10 user counter err", {31'b0, e}, 32'd0);
    check("R10 user counter data", d, 32'd0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d; logic e;
    rd(12'h7C0, 2'd3, d, e);
    check("R2 unimpl 0x7C0", {31'b0, e}, 32'd1);
    rd(12'h302, 2'd3, d, e);
    check("R2 unimpl 0x302", {31'b0, e}, 32'd1);
    rd(12'h7B1, 2'd3, d, e);
    check("R2 nodbg 0x7B1 err", {31'b0, err_nd}, 32'd1);
    check("R4 dbg 0x7B1 no err", {31'b0, e}, 32'd0);
  endtask

  task automatic t_debug();
    wr(12'h7B0, 32'hFFFF_FFFF, 2'd3);
    rd_chk("R3 dcsr mask", 12'h7B0, 32'h0000_89C4);
    wr(12'h7B1, 32'h1234_5679, 2'd3);
    wr(12'h7B2, 32'hA5A5_5A5A, 2'd3);
    wr(12'h7B3, 32'h0F0F_F0F0, 2'd3);
    rd_chk("R4 dpc", 12'h7B1, 32'h1234_5679);
    rd_chk("R4 dscratch0", 12'h7B2, 32'hA5A5_5A5A);
    rd_chk("R4 dscratch1", 12'h7B3, 32'h0F0F_F0F0);
  endtask

  task automatic t_irq_regs();
    wr(12'h344, 32'hFFFF_FFFF, 2'd3);
    rd_chk("R5 mip masked", 12'h344, 32'h0000_0808);
    mtip = 1'b1;
    wr(12'h344, 32'h0, 2'd3);
    rd_chk("R5 mtip from pin", 12'h344, 32'h0000_0080);
    mtip = 1'b0;
    wr(12'h304, 32'hFFFF_FFFF, 2'd3);
    rd_chk("R6 mie masked", 12'h304, 32'h0000_0888);
  endtask

  task automatic t_masks();
    wr(12'h305, 32'h8000_0007, 2'd3);
    rd_chk("R7 mtvec read", 12'h305, 32'h8000_0005);
    check("R7 mtvec port", mtvec, 32'h8000_0005);
    wr(12'h342, 32'hFFFF_FFFF, 2'd3);
    rd_chk("R8 mcause mask", 12'h342, 32'h8000_000F);
    wr(12'h341, 32'h0000_1003, 2'd3);
    rd_chk("R14 mepc write mask", 12'h341, 32'h0000_1002);
  endtask

  task automatic t_zero_counters();
    rd_chk("R10 B03", 12'hB03, 32'h0);
    rd_chk("R10 B9F", 12'hB9F, 32'h0);
    rd_chk("R10 323", 12'h323, 32'h0);
    rd_chk("R10 C1F", 12'hC1F, 32'h0);
  endtask

  task automatic t_traps();
    wr(12'h300, 32'h0000_0008, 2'd3);
    check("R11 irq_en after write", {31'b0, irq_en}, 32'd1);
    do_trap(1'b0, 4'd2, 32'h0000_2001, 32'h0000_ABCD, 32'h0);
    check("R12 irq_en cleared", {31'b0, irq_en}, 32'd0);
    rd_chk("R12 status after trap", 12'h300, 32'h0000_1880);
    rd_chk("R14 mepc aligned", 12'h341, 32'h0000_2000);
    rd_chk("R12 cause illegal", 12'h342, 32'h0000_0002);
    rd_chk("R13 short instr", 12'h343, 32'h0000_ABCD);
    do_mret();
    rd_chk("R11 status after mret", 12'h300, 32'h0000_1888);
    check("R11 irq_en after mret", {31'b0, irq_en}, 32'd1);
    do_trap(1'b0, 4'd2, 32'h0000_0100, 32'h1234_567B, 32'h0);
    rd_chk("R13 full instr", 12'h343, 32'h1234_567B);
    do_trap(1'b0, 4'd3, 32'h0000_0402, 32'h0, 32'h0);
    rd_chk("R13 breakpoint pc", 12'h343, 32'h0000_0402);
    do_trap(1'b0, 4'd11, 32'h0000_0500, 32'h0, 32'h0);
    rd_chk("R12 ecall cause", 12'h342, 32'h0000_000B);
    do_trap(1'b0, 4'd5, 32'h0000_0600, 32'h0, 32'h0000_DEAD);
    rd_chk("R13 other tval", 12'h343, 32'h0000_DEAD);
    do_trap(1'b1, 4'd7, 32'h0000_3000, 32'h0, 32'hFFFF);
    rd_chk("R12 irq cause", 12'h342, 32'h8000_0007);
    rd_chk("R13 irq tval", 12'h343, 32'h0);
    check("R12 mepc port", mepc, 32'h0000_3000);
    wr(12'h300, 32'h0, 2'd3);
    do_mret();
    rd_chk("R11 mret with mpie 0", 12'h300, 32'h0000_1880);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_reset();
    t_id_ignore();
    t_privilege();
    t_unimpl();
    t_debug();
    t_irq_regs();
    t_masks();
    t_zero_counters();
    t_traps();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule